// File: doc/BRIEF.md
# Radio Supply Power Sequencer

This block raises and lowers the enables of a radio's analog supply chain in a fixed order, leaving a timed gap between steps. Six enables are driven: crystal oscillator, bandgap, digital PLL, clock LDO, analog LDO and RF PLL. After the crystal is enabled, the sequencer waits a crystal-settle interval before it moves on. That interval is long in crystal mode and short in external-clock bypass mode. Each later step waits a common gap. Power-down walks the same chain backwards with the same gap.

A mode input selects between two kinds of control. In automatic mode, wake and sleep requests come from one-cycle register strobes or from the radio's own wake and sleep lines. Requests that arrive while a sequence is running are held and served once it ends. In manual mode, each enable takes the value of its own write strobe and data bit. The block also holds the 2-bit PLL output-select register while the digital PLL supply is on, and keeps the PLL run request from rising during that time.

States: `ST_OFF` (idle, chain down), `ST_XTAL_WAIT` (crystal settling), `ST_UP_GAP` (gap after each rising step), `ST_ON` (idle, chain up), `ST_DN_GAP` (gap after each falling step), `ST_SOFT` (manual mode). The transitions are:
- OFF→XTAL_WAIT on a wake request.
- XTAL_WAIT→UP_GAP when the settle time has passed and the crystal is ready.
- XTAL_WAIT→OFF on a crystal timeout.
- UP_GAP→UP_GAP for each further enable.
- UP_GAP→ON after the gap that follows the RF PLL.
- ON→DN_GAP on a sleep request.
- DN_GAP→DN_GAP for each further disable.
- DN_GAP→OFF after the gap that follows the crystal.
- any→SOFT while the mode input is 1.
- SOFT→OFF or SOFT→ON when the mode input returns to 0, depending on whether any enable is still set.

Top module: `rf_pwr_seq`

## Requirements
- R1: After reset, all enables, `busy`, `err`, `pll_sel` and `pll_run` are 0.
- R2: Enable bit positions are 0 crystal, 1 bandgap, 2 digital PLL, 3 clock LDO, 4 analog LDO, 5 RF PLL. In automatic mode, power-up sets them in ascending order and changes at most one enable per clock. The crystal enable rises on the first clock edge that sees a wake request in `ST_OFF`.
- R3: The bandgap enable rises T_XTAL_CYC cycles after the crystal enable when `xtal_ready` is high. In bypass mode it rises T_BYP_CYC cycles after the crystal enable, and `xtal_ready` is ignored.
- R4: Each enable from digital PLL to RF PLL rises T_GAP_CYC cycles after the previous one. `busy` falls T_GAP_CYC cycles after the RF PLL enable rises.
- R5: A sleep request in `ST_ON` clears the RF PLL enable on the next edge. The remaining enables then fall in descending order, T_GAP_CYC cycles apart. `busy` falls T_GAP_CYC cycles after the crystal enable falls.
- R6: A wake or sleep request arrives through either the strobe or the radio line. A request made while `busy` is held and served when the block next goes idle. When wake and sleep are pending together, wake is served and both are dropped.
- R7: In crystal mode, if `xtal_ready` is still low 2·T_XTAL_CYC cycles after the crystal enable rises, all enables clear, `busy` falls and `err` is set. `err` stays set until reset.
- R8: In manual mode, each enable whose write strobe is 1 takes its data bit on the next edge. Enables without a strobe keep their value. Wake and sleep requests have no effect.
- R9: A write to `pll_sel` is ignored while the digital PLL enable (bit 2) is 1, and is accepted otherwise.
- R10: `pll_run` follows `pll_en_req`, except that it cannot rise while the digital PLL enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_mode | input | 1 | 1 = manual per-bit control, 0 = automatic sequencing |
| xtal_bypass | input | 1 | External clock bypass: short settle time, ready not required |
| wake_strobe | input | 1 | Register wake request pulse |
| sleep_strobe | input | 1 | Register sleep request pulse |
| radio_wake | input | 1 | Wake request from the radio |
| radio_sleep | input | 1 | Sleep request from the radio |
| xtal_ready | input | 1 | Crystal oscillator stable |
| sw_en_wr | input | 6 | Manual-mode per-enable write strobes |
| sw_en_val | input | 6 | Manual-mode per-enable write data |
| sel_wr | input | 1 | PLL output-select write strobe |
| sel_wdata | input | 2 | PLL output-select write data |
| pll_en_req | input | 1 | Requested PLL run state |
| pwr_en | output | 6 | Supply enables, bit order as in R2 |
| busy | output | 1 | A power-up or power-down sequence is running |
| err | output | 1 | Sticky crystal timeout flag |
| pll_sel | output | 2 | PLL output-select register |
| pll_run | output | 1 | Guarded PLL run state |

## Verification
The crystal timeout is the hardest case to reach. The automatic flow normally sees `xtal_ready` high, and the timeout fires only after the full doubled settle window with the ready line still low. The bench holds `xtal_ready` at 0, issues a wake, and counts cycles until the crystal enable drops. It then raises ready and runs a full wake to show that `err` survives a successful sequence. Queued requests are reached by pulsing a sleep strobe in the middle of a power-up and timing the first falling step relative to the last rising one.

// File: rtl/rf_pwr_seq_pkg.sv
package rf_pwr_seq_pkg;

    localparam int EN_W  = 6;
    localparam int IDX_W = $clog2(EN_W);

    localparam int EN_XTAL   = 0;
    localparam int EN_BGAP   = 1;
    localparam int EN_DPLL   = 2;
    localparam int EN_LDOCLK = 3;
    localparam int EN_LDOANA = 4;
    localparam int EN_RFPLL  = 5;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_XTAL_WAIT,
        ST_UP_GAP,
        ST_ON,
        ST_DN_GAP,
        ST_SOFT
    } seq_state_t;

endpackage

// File: rtl/rf_step_timer.sv
module rf_step_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (cnt != {CNT_W{1'b1}}) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rf_pll_guard.sv
module rf_pll_guard #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_pll,
    input  logic             sel_wr,
    input  logic [SEL_W-1:0] sel_wdata,
    input  logic             pll_en_req,
    output logic [SEL_W-1:0] pll_sel,
    output logic             pll_run
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pll_sel <= '0;
            pll_run <= 1'b0;
        end else begin
            if (sel_wr && !pwr_pll) begin
                pll_sel <= sel_wdata;
            end
            pll_run <= pll_en_req && (pll_run || !pwr_pll);
        end
    end

    AST_SEL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pwr_pll) |-> $stable(pll_sel)); // R9

    AST_NO_PLL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_run) |-> !$past(pwr_pll)); // R10

endmodule

// File: rtl/rf_seq_ctrl.sv
module rf_seq_ctrl
    import rf_pwr_seq_pkg::*;
#(
    parameter int T_XTAL = 50000,
    parameter int T_BYP  = 50,
    parameter int T_GAP  = 50,
    parameter int CNT_W  = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_mode,
    input  logic             bypass,
    input  logic             wake_trig,
    input  logic             sleep_trig,
    input  logic             xtal_ready,
    input  logic [EN_W-1:0]  sw_en_wr,
    input  logic [EN_W-1:0]  sw_en_val,
    input  logic [CNT_W-1:0] cnt,
    output logic             tmr_clr,
    output logic [EN_W-1:0]  en,
    output logic             busy,
    output logic             err
);

    localparam logic [CNT_W-1:0] XT_LIM  = CNT_W'(T_XTAL - 1);
    localparam logic [CNT_W-1:0] BY_LIM  = CNT_W'(T_BYP - 1);
    localparam logic [CNT_W-1:0] TO_LIM  = CNT_W'(2 * T_XTAL - 1);
    localparam logic [CNT_W-1:0] GAP_LIM = CNT_W'(T_GAP - 1);
    localparam logic [IDX_W-1:0] LAST    = IDX_W'(EN_W - 1);

    seq_state_t       state, nxt;
    logic [IDX_W-1:0] idx, idx_nxt, idx_up, idx_dn;
    logic [EN_W-1:0]  en_nxt;
    logic             wake_pend, sleep_pend, eff_wake, eff_sleep;
    logic             serve, fault, settle_ok;

    assign eff_wake  = wake_pend  | wake_trig;
    assign eff_sleep = sleep_pend | sleep_trig;
    assign idx_up    = idx + 1'b1;
    assign idx_dn    = idx - 1'b1;
    assign settle_ok = bypass ? (cnt >= BY_LIM) : (cnt >= XT_LIM && xtal_ready);

    always_comb begin
        nxt     = state;
        idx_nxt = idx;
        en_nxt  = en;
        serve   = 1'b0;
        fault   = 1'b0;
        if (sw_mode) begin
            nxt = ST_SOFT;
            for (int i = 0; i < EN_W; i++) begin
                if (sw_en_wr[i]) en_nxt[i] = sw_en_val[i];
            end
        end else begin
            unique case (state)
                ST_OFF: begin
                    if (eff_wake) begin
                        serve           = 1'b1;
                        en_nxt[EN_XTAL] = 1'b1;
                        idx_nxt         = '0;
                        nxt             = ST_XTAL_WAIT;
                    end else if (eff_sleep) begin
                        serve = 1'b1;
                    end
                end
                ST_XTAL_WAIT: begin
                    if (settle_ok) begin
                        en_nxt[EN_BGAP] = 1'b1;
                        idx_nxt         = IDX_W'(EN_BGAP);
                        nxt             = ST_UP_GAP;
                    end else if (!bypass && cnt >= TO_LIM) begin
                        en_nxt = '0;
                        fault  = 1'b1;
                        nxt    = ST_OFF;
                    end
                end
                ST_UP_GAP: begin
                    if (cnt >= GAP_LIM) begin
                        if (idx == LAST) begin
                            nxt = ST_ON;
                        end else begin
                            idx_nxt        = idx_up;
                            en_nxt[idx_up] = 1'b1;
                        end
                    end
                end
                ST_ON: begin
                    if (eff_wake) begin
                        serve = 1'b1;
                    end else if (eff_sleep) begin
                        serve        = 1'b1;
                        en_nxt[LAST] = 1'b0;
                        idx_nxt      = LAST;
                        nxt          = ST_DN_GAP;
                    end
                end
                ST_DN_GAP: begin
                    if (cnt >= GAP_LIM) begin
                        if (idx == '0) begin
                            nxt = ST_OFF;
                        end else begin
                            idx_nxt        = idx_dn;
                            en_nxt[idx_dn] = 1'b0;
                        end
                    end
                end
                ST_SOFT: begin
                    serve = 1'b1;
                    nxt   = (en == '0) ? ST_OFF : ST_ON;
                end
                default: nxt = ST_OFF;
            endcase
        end
    end

    assign tmr_clr = (nxt != state) || (idx_nxt != idx);
    assign busy    = (state == ST_XTAL_WAIT) || (state == ST_UP_GAP) || (state == ST_DN_GAP);

    // state register and pending requests
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_OFF;
            idx        <= '0;
            wake_pend  <= 1'b0;
            sleep_pend <= 1'b0;
        end else begin
            state <= nxt;
            idx   <= idx_nxt;
            if (sw_mode || serve) begin
                wake_pend  <= 1'b0;
                sleep_pend <= 1'b0;
            end else begin
                wake_pend  <= eff_wake;
                sleep_pend <= eff_sleep;
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en  <= '0;
            err <= 1'b0;
        end else begin
            en  <= en_nxt;
            err <= err | fault;
        end
    end

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(sw_mode) && !$rose(err)) |-> ($countones(en ^ $past(en)) <= 1)); // R2

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err) |-> err); // R7

    AST_FAULT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> (en == '0 && !busy)); // R7

    generate
        for (genvar g = 1; g < EN_W; g++) begin : g_order
            AST_UP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
                ($rose(en[g]) && !$past(sw_mode)) |-> en[g-1]); // R2
            AST_DN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
                ($fell(en[g-1]) && !$past(sw_mode) && !$rose(err)) |-> !en[g]); // R5
        end
    endgenerate

endmodule

// File: rtl/rf_pwr_seq.sv
module rf_pwr_seq
    import rf_pwr_seq_pkg::*;
#(
    parameter int T_XTAL_CYC = 50000,
    parameter int T_BYP_CYC  = 50,
    parameter int T_GAP_CYC  = 50,
    parameter int SEL_W      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_mode,
    input  logic             xtal_bypass,
    input  logic             wake_strobe,
    input  logic             sleep_strobe,
    input  logic             radio_wake,
    input  logic             radio_sleep,
    input  logic             xtal_ready,
    input  logic [EN_W-1:0]  sw_en_wr,
    input  logic [EN_W-1:0]  sw_en_val,
    input  logic             sel_wr,
    input  logic [SEL_W-1:0] sel_wdata,
    input  logic             pll_en_req,
    output logic [EN_W-1:0]  pwr_en,
    output logic             busy,
    output logic             err,
    output logic [SEL_W-1:0] pll_sel,
    output logic             pll_run
);

    localparam int CNT_MAX = (2 * T_XTAL_CYC > T_GAP_CYC) ? 2 * T_XTAL_CYC : T_GAP_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic             tmr_clr;
    logic [CNT_W-1:0] cnt;

    rf_step_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .cnt   (cnt)
    );

    rf_seq_ctrl #(
        .T_XTAL (T_XTAL_CYC),
        .T_BYP  (T_BYP_CYC),
        .T_GAP  (T_GAP_CYC),
        .CNT_W  (CNT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_mode    (sw_mode),
        .bypass     (xtal_bypass),
        .wake_trig  (wake_strobe | radio_wake),
        .sleep_trig (sleep_strobe | radio_sleep),
        .xtal_ready (xtal_ready),
        .sw_en_wr   (sw_en_wr),
        .sw_en_val  (sw_en_val),
        .cnt        (cnt),
        .tmr_clr    (tmr_clr),
        .en         (pwr_en),
        .busy       (busy),
        .err        (err)
    );

    rf_pll_guard #(.SEL_W(SEL_W)) u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_pll    (pwr_en[EN_DPLL]),
        .sel_wr     (sel_wr),
        .sel_wdata  (sel_wdata),
        .pll_en_req (pll_en_req),
        .pll_sel    (pll_sel),
        .pll_run    (pll_run)
    );

endmodule

// File: tb/rf_pwr_seq_tb.sv
module rf_pwr_seq_tb_top;

    localparam int TX = 20;
    localparam int TB = 3;
    localparam int TG = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_mode = 1'b0, xtal_bypass = 1'b0;
    logic       wake_strobe = 1'b0, sleep_strobe = 1'b0;
    logic       radio_wake = 1'b0, radio_sleep = 1'b0;
    logic       xtal_ready = 1'b1;
    logic [5:0] sw_en_wr = '0, sw_en_val = '0;
    logic       sel_wr = 1'b0;
    logic [1:0] sel_wdata = '0;
    logic       pll_en_req = 1'b0;
    logic [5:0] pwr_en;
    logic       busy, err, pll_run;
    logic [1:0] pll_sel;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    rf_pwr_seq #(.T_XTAL_CYC(TX), .T_BYP_CYC(TB), .T_GAP_CYC(TG)) dut_i (
        .clk(clk), .rst_n(rst_n), .sw_mode(sw_mode), .xtal_bypass(xtal_bypass),
        .wake_strobe(wake_strobe), .sleep_strobe(sleep_strobe),
        .radio_wake(radio_wake), .radio_sleep(radio_sleep), .xtal_ready(xtal_ready),
        .sw_en_wr(sw_en_wr), .sw_en_val(sw_en_val), .sel_wr(sel_wr),
        .sel_wdata(sel_wdata), .pll_en_req(pll_en_req), .pwr_en(pwr_en),
        .busy(busy), .err(err), .pll_sel(pll_sel), .pll_run(pll_run)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_en(input int b, input logic v, input int lim, output int n);
        n = 0;
        while (n < lim) begin
            @(posedge clk); #1;
            n++;
            if (pwr_en[b] == v) break;
        end
    endtask

    task automatic wait_idle(input int lim, output int n);
        n = 0;
        while (n < lim) begin
            @(posedge clk); #1;
            n++;
            if (!busy) break;
        end
    endtask

    task automatic full_up(input string req, input int first);
        int n;
        wait_en(0, 1'b1, 4, n);
        chk(n == 1, {req, " crystal first"}, n, 1);
        wake_strobe = 1'b0; radio_wake = 1'b0; sleep_strobe = 1'b0; radio_sleep = 1'b0;
        wait_en(1, 1'b1, 3 * TX, n);
        chk(n == first, {req, " bandgap delay"}, n, first);
        for (int k = 2; k < 6; k++) begin
            wait_en(k, 1'b1, 3 * TG, n);
            chk(n == TG && pwr_en == 6'((1 << (k + 1)) - 1), "R4 up gap/order R2", n, TG);
        end
        wait_idle(3 * TG, n);
        chk(n == TG && pwr_en == 6'h3F, "R4 busy fall after last", n, TG);
    endtask

    task automatic full_down(input string req);
        int n;
        wait_en(5, 1'b0, 4, n);
        chk(n == 1, {req, " rf pll first off"}, n, 1);
        sleep_strobe = 1'b0; radio_sleep = 1'b0;
        for (int k = 4; k >= 0; k--) begin
            wait_en(k, 1'b0, 3 * TG, n);
            chk(n == TG && pwr_en == 6'((1 << k) - 1), "R5 down gap/order", n, TG);
        end
        wait_idle(3 * TG, n);
        chk(n == TG && pwr_en == 6'h00, "R5 busy fall after crystal", n, TG);
    endtask

    task automatic t_reset;
        chk(pwr_en == 0 && !busy && !err && pll_sel == 0 && !pll_run, "R1 reset state",
            int'(pwr_en), 0);
    endtask

    task automatic t_strobe_cycle;
        @(negedge clk) wake_strobe = 1'b1;
        full_up("R2 R3 strobe", TX);
        @(negedge clk) radio_sleep = 1'b1;
        full_down("R5 R6 radio");
    endtask

    task automatic t_bypass;
        xtal_ready = 1'b0;
        xtal_bypass = 1'b1;
        @(negedge clk) radio_wake = 1'b1;
        full_up("R3 bypass R6", TB);
        @(negedge clk) sleep_strobe = 1'b1;
        full_down("R5 strobe");
        xtal_bypass = 1'b0;
        xtal_ready = 1'b1;
    endtask

    task automatic t_queue;
        int n;
        @(negedge clk) wake_strobe = 1'b1;
        @(negedge clk) wake_strobe = 1'b0;
        repeat (3) @(negedge clk);
        sleep_strobe = 1'b1;
        @(negedge clk) sleep_strobe = 1'b0;
        chk(busy == 1'b1, "R6 sleep arrived while busy", busy, 1);
        wait_en(5, 1'b1, 4 * TX, n);
        wait_en(5, 1'b0, 4 * TG, n);
        chk(n == TG + 1, "R6 queued sleep served after idle", n, TG + 1);
        wait_en(0, 1'b0, 10 * TG, n);
        wait_idle(3 * TG, n);
        chk(pwr_en == 0 && !busy, "R6 queued sleep completes", int'(pwr_en), 0);
    endtask

    task automatic t_priority;
        @(negedge clk) begin wake_strobe = 1'b1; radio_sleep = 1'b1; end
        full_up("R6 wake wins", TX);
        repeat (10) @(negedge clk);
        chk(pwr_en == 6'h3F, "R6 simultaneous sleep dropped", int'(pwr_en), 63);
        @(negedge clk) sleep_strobe = 1'b1;
        full_down("R5 after priority");
    endtask

    task automatic t_timeout;
        int n;
        xtal_ready = 1'b0;
        @(negedge clk) wake_strobe = 1'b1;
        wait_en(0, 1'b1, 4, n);
        wake_strobe = 1'b0;
        wait_en(0, 1'b0, 4 * TX, n);
        chk(n == 2 * TX, "R7 timeout delay", n, 2 * TX);
        chk(pwr_en == 0 && err && !busy, "R7 fault state", int'(err), 1);
        xtal_ready = 1'b1;
        @(negedge clk) wake_strobe = 1'b1;
        full_up("R7 retry", TX);
        chk(err == 1'b1, "R7 err sticky", err, 1);
        @(negedge clk) sleep_strobe = 1'b1;
        full_down("R5 after retry");
    endtask

    task automatic t_soft_and_guard;
        @(negedge clk);
        sel_wr = 1'b1; sel_wdata = 2'd2; pll_en_req = 1'b1;
        @(negedge clk) sel_wr = 1'b0;
        chk(pll_sel == 2'd2, "R9 write accepted while off", pll_sel, 2);
        chk(pll_run == 1'b1, "R10 run follows request while off", pll_run, 1);
        pll_en_req = 1'b0;
        sw_mode = 1'b1;
        sw_en_wr = 6'b000101; sw_en_val = 6'b000101;
        @(negedge clk) sw_en_wr = '0;
        chk(pwr_en == 6'h05, "R8 manual write", int'(pwr_en), 5);
        sw_en_wr = 6'b000010; sw_en_val = 6'b111111;
        @(negedge clk) sw_en_wr = '0;
        chk(pwr_en == 6'h07, "R8 unwritten bits hold", int'(pwr_en), 7);
        chk(pll_run == 1'b0, "R10 run falls", pll_run, 0);
        wake_strobe = 1'b1; radio_sleep = 1'b1;
        sel_wr = 1'b1; sel_wdata = 2'd1; pll_en_req = 1'b1;
        @(negedge clk) begin wake_strobe = 1'b0; radio_sleep = 1'b0; sel_wr = 1'b0; end
        repeat (4) @(negedge clk);
        chk(pwr_en == 6'h07, "R8 triggers ignored", int'(pwr_en), 7);
        chk(pll_sel == 2'd2, "R9 write blocked while powered", pll_sel, 2);
        chk(pll_run == 1'b0, "R10 rise suppressed while powered", pll_run, 0);
        sw_en_wr = 6'b000100; sw_en_val = 6'b000000;
        @(negedge clk) sw_en_wr = '0;
        @(negedge clk);
        chk(pll_run == 1'b1, "R10 run rises after power off", pll_run, 1);
        sel_wr = 1'b1; sel_wdata = 2'd3;
        @(negedge clk) sel_wr = 1'b0;
        chk(pll_sel == 2'd3, "R9 write accepted after power off", pll_sel, 3);
        pll_en_req = 1'b0;
        sw_en_wr = 6'h3F; sw_en_val = 6'h00;
        @(negedge clk) begin sw_en_wr = '0; sw_mode = 1'b0; end
        repeat (5) @(negedge clk);
        chk(pwr_en == 0 && !busy, "R8 return to automatic idle", int'(pwr_en), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_strobe_cycle();
        t_bypass();
        t_queue();
        t_priority();
        t_soft_and_guard();
        t_timeout();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule